// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block is the digital output side of a sampling analog-to-digital converter with a 12-bit result. It forms one serial frame for each conversion. The frame begins when the active-low chip select falls. A short sampling window follows, with the output released. The block then drives a single low null bit. After that it sends the result most-significant bit first, then sends the same word again least-significant bit first. The final bit is not repeated at the turn. The output is then released for good, and further clocks are ignored until chip select goes high and falls again.

The block runs on a fast system clock, and both the serial data clock and the chip select are sampled as synchronous inputs. A falling serial-clock edge is the one event that advances the frame. The serial output is a data bit paired with an enable flag, and the pad tri-state is built from the two. The block also drives a power-down flag for the analog core. It rises once the conversion bits are finished and falls when chip select rises. The conversion result comes in on a parallel port and is captured when the frame starts.

Top module: `adc_serial_out`

## Requirements
- R1: A frame starts only on a high-to-low transition of `cs_n` seen across two system-clock samples. Holding `cs_n` low through reset starts no frame, and serial clocks then leave `sdo_oe` at 0.
- R2: `sdo_oe` stays 0 after the frame starts and through the first falling `sclk` edge. It becomes 1 on the second falling edge.
- R3: From the second falling edge until the third, the block drives `sdo_oe` = 1 and `sdo` = 0 (the null bit).
- R4: On falling edges 3 to 14 the output carries result bits 11 down to 0, one bit per edge, so edge k carries bit 14-k.
- R5: On falling edges 15 to 25 the output carries result bits 1 up to 11, so edge k carries bit k-14. Bit 0 is not sent a second time.
- R6: From falling edge 26 on, `sdo_oe` is 0. Any number of further falling edges keeps it 0 while `cs_n` stays low.
- R7: When `cs_n` is high at a clock edge, `sdo_oe` and `pwr_down` are 0 after that edge, whatever the frame phase was.
- R8: `pwr_down` is 1 from falling edge 15 until `cs_n` is seen high, and 0 at every other time.
- R9: The result is taken from `conv_data` on the clock edge that sees chip select fall. Later changes on `conv_data` do not affect the frame.
- R10: Outputs change only on the system-clock edge that first samples `sclk` low after a high sample. While `sclk` is high or held steady, they do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, synchronous to `clk` |
| sclk | input | 1 | Serial data clock, synchronous to `clk` |
| conv_data | input | 12 | Parallel conversion result |
| sdo | output | 1 | Serial data bit, 0 while released |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| pwr_down | output | 1 | Analog core shutdown indication |

## Verification
Several rules are checked by assertions on every cycle. The output is released after any cycle with chip select high, and the power-down flag clears at the same time. The enable never rises on anything other than a low bit. Nothing on the outputs moves without a falling serial edge or a chip-select change. The bit order at the MSB-to-LSB turn and the capture of the word at frame start are also checked this way. The bench scenarios are needed for the rest. These cover the full bit order of both halves against a given word, the release at edge 26 and the edges after it, frames cut short at random points, and the capture staying fixed while the input port keeps changing.

// File: rtl/sdo_seq_pkg.sv
// Shared types for the serial ADC output sequencer.
// Assumes: one frame phase encoding is used by every submodule.
package sdo_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,   // no frame, output released
        PH_SAMP0 = 3'd1,   // sampling window, before first falling edge
        PH_SAMP1 = 3'd2,   // sampling window, after first falling edge
        PH_NULL  = 3'd3,   // driving the low null bit
        PH_MSB   = 3'd4,   // word, most significant bit first
        PH_LSB   = 3'd5,   // word repeat, least significant bit first
        PH_DONE  = 3'd6    // frame finished, released until chip select rises
    } frame_phase_e;

endpackage

// File: rtl/sdo_edge_det.sv
// Falling-edge detector for a level sampled on the system clock.
// Assumes: sig is already synchronous to clk. INIT is the value the history
// register takes in reset, so choosing 0 suppresses a false fall after reset.
module sdo_edge_det #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);

    logic sig_q;

    // Remember the previous sample of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= INIT;
        else        sig_q <= sig;
    end

    // A fall is a high previous sample against a low present one.
    assign fall = sig_q & ~sig;

endmodule

// File: rtl/sdo_frame_seq.sv
// Frame phase sequencer: counts falling serial-clock edges through the
// sampling window, null bit, MSB-first word, LSB-first repeat and release.
// Assumes: frame_start and sclk_fall are single-cycle strobes on clk.
module sdo_frame_seq
    import sdo_seq_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       frame_start,
    input  logic                       sclk_fall,
    output frame_phase_e               phase,
    output logic [$clog2(WIDTH)-1:0]   bit_idx,
    output logic                       drive_en,
    output logic                       pwr_down
);

    localparam int IDXW = $clog2(WIDTH);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(WIDTH - 1);

    // Advance the phase and bit index on each falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
        end else if (cs_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
        end else if (frame_start) begin
            phase   <= PH_SAMP0;
            bit_idx <= '0;
        end else if (sclk_fall) begin
            case (phase)
                PH_SAMP0: phase <= PH_SAMP1;
                PH_SAMP1: phase <= PH_NULL;
                PH_NULL: begin
                    phase   <= PH_MSB;
                    bit_idx <= LAST_IDX;
                end
                PH_MSB: begin
                    if (bit_idx == '0) begin
                        phase   <= PH_LSB;
                        bit_idx <= IDXW'(1);
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                PH_LSB: begin
                    if (bit_idx == LAST_IDX) begin
                        phase   <= PH_DONE;
                        bit_idx <= '0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Pad enable covers the null bit and both word halves.
    assign drive_en = (phase == PH_NULL) || (phase == PH_MSB) || (phase == PH_LSB);
    // Core shutdown once the first word half is done, until chip select rises.
    assign pwr_down = (phase == PH_LSB) || (phase == PH_DONE);

    // R5: at the turn the repeat starts at bit 1, never at bit 0.
    a_r5_turn_skips_b0: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MSB && bit_idx == '0 && sclk_fall && !cs_n && !frame_start)
        |=> (phase == PH_LSB && bit_idx == IDXW'(1)));

    // R6: a finished frame stays finished while chip select is low.
    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !cs_n && !frame_start) |=> (phase == PH_DONE));

endmodule

// File: rtl/sdo_word_hold.sv
// Result capture and serial bit select.
// Assumes: frame_start marks the cycle chip select is seen falling; the word
// is held until the next frame_start.
module sdo_word_hold
    import sdo_seq_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic [WIDTH-1:0]           conv_data,
    input  frame_phase_e               phase,
    input  logic [$clog2(WIDTH)-1:0]   bit_idx,
    output logic                       sdo
);

    logic [WIDTH-1:0] word_q;

    // Capture the conversion result at frame start only.
    always_ff @(posedge clk) begin
        if (!rst_n)           word_q <= '0;
        else if (frame_start) word_q <= conv_data;
    end

    // Select the addressed bit during the word phases, else drive low.
    always_comb begin
        if (phase == PH_MSB || phase == PH_LSB) sdo = word_q[bit_idx];
        else                                    sdo = 1'b0;
    end

    // R9: the held word is the value on the port at frame start.
    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (word_q == $past(conv_data)));

endmodule

// File: rtl/adc_serial_out.sv
// Top of the serial ADC output sequencer. Detects chip-select and
// serial-clock falls on the system clock, sequences one frame per
// conversion and drives the serial data bit, its enable and power-down.
// Assumes: cs_n and sclk are synchronous to clk, and each sclk level lasts
// at least one clk cycle.
module adc_serial_out
    import sdo_seq_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [WIDTH-1:0] conv_data,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             pwr_down
);

    localparam int IDXW = $clog2(WIDTH);

    logic            cs_fall;
    logic            sclk_fall;
    frame_phase_e    phase;
    logic [IDXW-1:0] bit_idx;

    // History reset low: chip select held low through reset starts nothing.
    sdo_edge_det #(.INIT(1'b0)) u_cs_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (cs_n),
        .fall  (cs_fall)
    );

    // History reset low: no false serial edge after reset.
    sdo_edge_det #(.INIT(1'b0)) u_sclk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (sclk),
        .fall  (sclk_fall)
    );

    sdo_frame_seq #(.WIDTH(WIDTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .frame_start (cs_fall),
        .sclk_fall   (sclk_fall),
        .phase       (phase),
        .bit_idx     (bit_idx),
        .drive_en    (sdo_oe),
        .pwr_down    (pwr_down)
    );

    sdo_word_hold #(.WIDTH(WIDTH)) u_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (cs_fall),
        .conv_data   (conv_data),
        .phase       (phase),
        .bit_idx     (bit_idx),
        .sdo         (sdo)
    );

    // R7: chip select high releases the output on the next edge.
    a_r7_cs_high_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);

    // R8: chip select high clears the power-down flag.
    a_r8_cs_high_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !pwr_down);

    // R3: the enable only ever rises on the low null bit.
    a_r3_null_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    // R10: without a serial fall or chip-select change the outputs hold.
    a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_n && !cs_fall)
        |=> ($stable(sdo) && $stable(sdo_oe) && $stable(pwr_down)));

endmodule

// File: tb/adc_serial_out_tb_top.sv
// Bench for adc_serial_out: directed corner frames plus seeded random
// frames, compared against an edge-count model of the frame.
module adc_serial_out_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b0;
    logic         sclk = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         sdo;
    logic         sdo_oe;
    logic         pwr_down;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_serial_out #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .conv_data (conv_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .pwr_down  (pwr_down)
    );

    // Expected enable after k falling edges in a frame.
    function automatic logic exp_oe(int k);
        return (k >= 2 && k <= 25);
    endfunction

    // Expected data bit after k falling edges for word w.
    function automatic logic exp_sdo(int k, logic [W-1:0] w);
        if (k >= 3 && k <= 14)  return w[14 - k];
        if (k >= 15 && k <= 25) return w[k - 14];
        return 1'b0;
    endfunction

    function automatic logic exp_pwr(int k);
        return (k >= 15);
    endfunction

    // Requirement tag for an edge count.
    function automatic string tag_of(int k);
        if (k < 2)   return "R2";
        if (k == 2)  return "R3";
        if (k <= 14) return "R4";
        if (k <= 25) return "R5";
        return "R6";
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model for k edges.
    task automatic check_state(string req, int k, logic [W-1:0] w);
        check_bit({req, " oe"}, sdo_oe, exp_oe(k));
        if (exp_oe(k)) check_bit({req, " sdo"}, sdo, exp_sdo(k, w));
        check_bit({"R8 pwr (", req, ")"}, pwr_down, exp_pwr(k));
    endtask

    // One serial clock period: high for a cycle, then a falling edge.
    task automatic sclk_pulse();
        @(negedge clk) sclk = 1'b1;
        @(negedge clk) sclk = 1'b0;
        @(negedge clk);
    endtask

    // Run a frame of n edges; optionally scramble conv_data after start.
    task automatic run_frame(logic [W-1:0] w, int n, bit scramble);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) begin
            cs_n = 1'b0;
            conv_data = w;
        end
        @(negedge clk);
        check_state("R1 start", 0, w);
        for (int k = 1; k <= n; k++) begin
            if (scramble) conv_data = W'($urandom);
            @(negedge clk) sclk = 1'b1;
            @(negedge clk);
            // R10: sclk high alone leaves outputs unchanged.
            check_state("R10 hold", k - 1, w);
            if (scramble) conv_data = W'($urandom);
            sclk = 1'b0;
            @(negedge clk);
            check_state(scramble ? {tag_of(k), " R9"} : tag_of(k), k, w);
            // R10: extra cycles with sclk low change nothing.
            @(negedge clk);
            check_state("R10 steady", k, w);
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        check_bit("R7 oe after cs high", sdo_oe, 1'b0);
        check_bit("R7 pwr after cs high", pwr_down, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Reset with chip select held low.
        repeat (4) @(negedge clk);
        check_bit("R1 reset oe", sdo_oe, 1'b0);
        check_bit("R1 reset pwr", pwr_down, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            sclk_pulse();
            check_bit("R1 no frame without cs fall", sdo_oe, 1'b0);
        end
        // Directed full frames with corner words.
        run_frame(12'hA5C, 30, 1'b0);
        run_frame(12'h000, 28, 1'b0);
        run_frame(12'hFFF, 28, 1'b0);
        run_frame(12'h801, 40, 1'b0);
        run_frame(12'h3C6, 27, 1'b1);
        // Aborted frames at the boundaries.
        run_frame(12'h5A5, 1, 1'b0);
        run_frame(12'h5A5, 2, 1'b0);
        run_frame(12'h5A5, 14, 1'b0);
        run_frame(12'h5A5, 15, 1'b0);
        // Seeded random frames.
        for (int f = 0; f < 40; f++) begin
            run_frame(W'($urandom), int'($urandom_range(0, 32)), 1'($urandom));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule